// File: doc/BRIEF.md
# Static Direction Branch Predictor with Misprediction Flush

This block chooses the next fetch address for a simple in-order pipeline. In the fetch stage it looks at a conditional branch's signed word offset. If the offset is negative, the branch points backward, as a loop-closing branch does, and the block guesses taken: the next PC is the branch target. If the offset is zero or positive, the branch points forward, as a skip over an if-body does, and the block guesses not taken: fetch runs on to PC+4 with no bubble.

One cycle later the branch sits in the decode stage, where the comparison logic outside this block settles the real outcome. The block keeps the branch's PC, offset and guess in a one-entry decode slot. When the outcome disagrees with the guess, the block raises a flush for the IF/ID register, which squashes the one wrongly fetched instruction. It also overrides the next PC with the correct address: the target if the branch was taken, or the branch PC+4 if it was not. A 16-bit saturating counter totals these misses.

The surrounding PC register loads `next_pc` every cycle. Instruction memory and the operand comparison are outside this block.

Top module: `static_br_pred`

## Requirements
- R1: While reset is held, `ifid_flush` is 0 and `mispredict_cnt` is 0. With no branch at fetch, `next_pc` is `pc_if`+4.
- R2: With no tracked branch in decode and `br_found`=0, `next_pc` is `pc_if`+4 and `ifid_flush` is 0.
- R3: A fetched branch whose offset has sign bit 1 (backward) is guessed taken: `next_pc` = `pc_if` + sign-extended `br_offset`×4 in the same cycle.
- R4: A fetched branch whose offset has sign bit 0 (forward, zero included) is guessed not taken: `next_pc` = `pc_if`+4.
- R5: In the cycle after a tracked branch, `br_taken_id` gives its outcome (1 = taken). If it matches the guess, `ifid_flush` stays 0 and `next_pc` follows the fetch rule of R2 to R4.
- R6: A backward branch that resolves not taken raises `ifid_flush` for that one cycle, and `next_pc` becomes the branch PC+4.
- R7: A forward branch that resolves taken raises `ifid_flush` for that one cycle, and `next_pc` becomes the branch PC + offset×4.
- R8: `mispredict_cnt` rises by one in the cycle after each flush. It holds at 16'hFFFF once it reaches that value.
- R9: A branch fetched in a flush cycle is squashed and is not tracked. While no branch is tracked, `br_taken_id` has no effect on `ifid_flush`, `next_pc` or `mispredict_cnt`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pc_if | input | PC_W | Address of the instruction in fetch |
| br_found | input | 1 | Instruction in fetch is a conditional branch |
| br_offset | input | OFF_W | Signed word offset of that branch |
| br_taken_id | input | 1 | Resolved outcome of the branch now in decode |
| next_pc | output | PC_W | Address to fetch next |
| ifid_flush | output | 1 | Squash the IF/ID register this cycle |
| mispredict_cnt | output | CNT_W | Saturating count of mispredictions |

## Verification
The bench replays loop-shaped traces, where the last pass through the loop exits against the guess, and skip-shaped traces, where a forward branch is taken. A design that mixed up the two recovery addresses would send the PC to the target after a loop exit, or to PC+4 after a taken skip. It also places a branch in the flush cycle and drives an outcome that disagrees with that branch's guess. A design that kept tracking the squashed branch would flush a second time. Other cases are a zero offset, which must count as forward, two branches back to back, and a long run of misses. A design with a wrapping counter would drop from 16'hFFFF to 0 during that run.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
   typedef enum logic {
      PRED_NOT_TAKEN = 1'b0,
      PRED_TAKEN     = 1'b1
   } pred_e;
endpackage

// File: rtl/sbp_tgt_calc.sv
// Sequential and branch-target address arithmetic.
module sbp_tgt_calc #(
   parameter int PC_W  = 32,
   parameter int OFF_W = 16,
   parameter int SHIFT = 2
) (
   input  logic [PC_W-1:0]  pc,
   input  logic [OFF_W-1:0] off,
   output logic [PC_W-1:0]  seq_pc,
   output logic [PC_W-1:0]  tgt_pc
);
   localparam int EXT_W = PC_W - OFF_W;
   localparam logic [PC_W-1:0] STEP = PC_W'(1 << SHIFT);

   logic [PC_W-1:0] off_ext;
   logic [PC_W-1:0] off_scaled;

   assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};

   generate
      if (SHIFT == 0) begin : g_byte_units
         assign off_scaled = off_ext;
      end else begin : g_word_units
         assign off_scaled = {off_ext[PC_W-1-SHIFT:0], {SHIFT{1'b0}}};
      end
   endgenerate

   assign seq_pc = pc + STEP;
   assign tgt_pc = pc + off_scaled;
endmodule

// File: rtl/sbp_dir_predict.sv
// Fetch-stage guess: backward offset -> taken, otherwise sequential.
module sbp_dir_predict
   import sbp_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int OFF_W = 16,
   parameter int SHIFT = 2
) (
   input  logic [PC_W-1:0]  pc,
   input  logic             br_found,
   input  logic [OFF_W-1:0] off,
   output pred_e            pred,
   output logic [PC_W-1:0]  pred_pc
);
   logic [PC_W-1:0] seq_pc;
   logic [PC_W-1:0] tgt_pc;

   sbp_tgt_calc #(.PC_W(PC_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_calc (
      .pc     (pc),
      .off    (off),
      .seq_pc (seq_pc),
      .tgt_pc (tgt_pc)
   );

   always_comb begin
      pred = (br_found && off[OFF_W-1]) ? PRED_TAKEN : PRED_NOT_TAKEN;
      pred_pc = (pred == PRED_TAKEN) ? tgt_pc : seq_pc;
   end
endmodule

// File: rtl/sbp_id_slot.sv
// One-entry record of the branch in decode, and its resolution.
module sbp_id_slot
   import sbp_pkg::*;
#(
   parameter int PC_W  = 32,
   parameter int OFF_W = 16,
   parameter int SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture,
   input  logic [PC_W-1:0]  pc_in,
   input  logic [OFF_W-1:0] off_in,
   input  pred_e            pred_in,
   input  logic             taken,
   output logic             mispredict,
   output logic [PC_W-1:0]  fix_pc
);
   logic             slot_vld;
   logic [PC_W-1:0]  slot_pc;
   logic [OFF_W-1:0] slot_off;
   pred_e            slot_pred;
   logic [PC_W-1:0]  seq_pc;
   logic [PC_W-1:0]  tgt_pc;

   sbp_tgt_calc #(.PC_W(PC_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_calc (
      .pc     (slot_pc),
      .off    (slot_off),
      .seq_pc (seq_pc),
      .tgt_pc (tgt_pc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         slot_vld  <= 1'b0;
         slot_pc   <= '0;
         slot_off  <= '0;
         slot_pred <= PRED_NOT_TAKEN;
      end else begin
         slot_vld <= capture && !mispredict;
         if (capture) begin
            slot_pc   <= pc_in;
            slot_off  <= off_in;
            slot_pred <= pred_in;
         end
      end
   end

   always_comb begin
      mispredict = slot_vld && (taken != (slot_pred == PRED_TAKEN));
      fix_pc     = taken ? tgt_pc : seq_pc;
   end

   AST_SLOT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      mispredict |=> !slot_vld) else $error("squashed branch tracked"); // R9
endmodule

// File: rtl/sbp_sat_counter.sv
// Saturating event counter.
module sbp_sat_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (inc && cnt != TOP)  cnt <= cnt + 1'b1;
   end

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && cnt != TOP) |=> cnt == $past(cnt) + 1'b1) else $error("count step"); // R8
   AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == TOP) |=> cnt == TOP) else $error("count wrapped"); // R8
   AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !inc |=> $stable(cnt)) else $error("count moved idle"); // R9
endmodule

// File: rtl/static_br_pred.sv
module static_br_pred
   import sbp_pkg::*;
#(
   parameter int PC_W        = 32,
   parameter int OFF_W       = 16,
   parameter int INSTR_BYTES = 4,
   parameter int CNT_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PC_W-1:0]  pc_if,
   input  logic             br_found,
   input  logic [OFF_W-1:0] br_offset,
   input  logic             br_taken_id,
   output logic [PC_W-1:0]  next_pc,
   output logic             ifid_flush,
   output logic [CNT_W-1:0] mispredict_cnt
);
   localparam int SHIFT = $clog2(INSTR_BYTES);
   localparam logic [PC_W-1:0] STEP = PC_W'(INSTR_BYTES);

   generate
      if ((1 << SHIFT) != INSTR_BYTES) begin : g_bad_step
         $error("INSTR_BYTES must be a power of two");
      end
      if (PC_W <= OFF_W + SHIFT) begin : g_bad_width
         $error("PC_W must exceed OFF_W plus the offset shift");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("CNT_W must be at least 1");
      end
   endgenerate

   pred_e           if_pred;
   logic [PC_W-1:0] if_pred_pc;
   logic            mispredict;
   logic [PC_W-1:0] fix_pc;

   sbp_dir_predict #(.PC_W(PC_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_pred (
      .pc       (pc_if),
      .br_found (br_found),
      .off      (br_offset),
      .pred     (if_pred),
      .pred_pc  (if_pred_pc)
   );

   sbp_id_slot #(.PC_W(PC_W), .OFF_W(OFF_W), .SHIFT(SHIFT)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .capture    (br_found),
      .pc_in      (pc_if),
      .off_in     (br_offset),
      .pred_in    (if_pred),
      .taken      (br_taken_id),
      .mispredict (mispredict),
      .fix_pc     (fix_pc)
   );

   sbp_sat_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (mispredict),
      .cnt   (mispredict_cnt)
   );

   assign ifid_flush = mispredict;
   assign next_pc    = mispredict ? fix_pc : if_pred_pc;

   // Reference offset for checks, built separately from the target adders.
   logic [PC_W-1:0] chk_off;
   assign chk_off = PC_W'($signed(br_offset)) * STEP;

   AST_FWD_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
      (!ifid_flush && !(br_found && br_offset[OFF_W-1])) |-> next_pc == pc_if + STEP)
      else $error("sequential fetch"); // R4
   AST_BACK_TGT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ifid_flush && br_found && br_offset[OFF_W-1]) |-> next_pc == pc_if + chk_off)
      else $error("backward guess"); // R3
   AST_FLUSH_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_flush |=> !ifid_flush) else $error("flush repeated"); // R6
   AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      ifid_flush |-> $past(br_found)) else $error("flush without branch"); // R9
   AST_FIX_NT: assert property (@(posedge clk) disable iff (!rst_n)
      (ifid_flush && !br_taken_id) |-> next_pc == $past(pc_if) + STEP)
      else $error("not-taken repair"); // R6
   AST_FIX_T: assert property (@(posedge clk) disable iff (!rst_n)
      (ifid_flush && br_taken_id) |-> next_pc == $past(pc_if) + $past(chk_off))
      else $error("taken repair"); // R7
endmodule

// File: tb/static_br_pred_tb.sv
module static_br_pred_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pc_if = 32'h0000_0100;
   logic        br_found = 1'b0;
   logic [15:0] br_offset = '0;
   logic        br_taken_id = 1'b0;
   logic [31:0] next_pc;
   logic        ifid_flush;
   logic [15:0] mispredict_cnt;

   int total = 0;
   int bad = 0;

   static_br_pred u_dut (
      .clk            (clk),
      .rst_n          (rst_n),
      .pc_if          (pc_if),
      .br_found       (br_found),
      .br_offset      (br_offset),
      .br_taken_id    (br_taken_id),
      .next_pc        (next_pc),
      .ifid_flush     (ifid_flush),
      .mispredict_cnt (mispredict_cnt)
   );

   always #2.5 clk = ~clk;

   // scoreboard queues
   logic [31:0] q_pc[$];
   logic        q_fl[$];
   logic [15:0] q_cnt[$];
   string       q_tag[$];

   // bench model state, from the requirements
   logic        m_vld = 1'b0;
   logic [31:0] m_pc = '0;
   logic [15:0] m_off = '0;
   logic        m_pred = 1'b0;
   logic [15:0] m_cnt = '0;
   logic [31:0] cur_pc = 32'h0000_1000;

   function automatic logic [31:0] target(input logic [31:0] pc, input logic [15:0] off);
      int signed o;
      o = $signed(off);
      return pc + 32'(o * 4);
   endfunction

   task automatic step(input logic br, input logic [15:0] off, input logic tk, input string tag);
      logic        mis;
      logic [31:0] nxt;
      @(posedge clk);
      #1;
      pc_if = cur_pc;
      br_found = br;
      br_offset = off;
      br_taken_id = tk;
      mis = m_vld && (tk != m_pred);
      if (mis) nxt = tk ? target(m_pc, m_off) : m_pc + 32'd4;
      else if (br && off[15]) nxt = target(cur_pc, off);
      else nxt = cur_pc + 32'd4;
      q_pc.push_back(nxt);
      q_fl.push_back(mis);
      q_cnt.push_back(m_cnt);
      q_tag.push_back(tag);
      m_vld = br && !mis;
      m_pc = cur_pc;
      m_off = off;
      m_pred = off[15];
      if (mis && m_cnt != 16'hFFFF) m_cnt = m_cnt + 16'd1;
      cur_pc = nxt;
   endtask

   // monitor
   always @(negedge clk) begin
      if (q_pc.size() > 0) begin
         logic [31:0] epc;
         logic        efl;
         logic [15:0] ec;
         string       t;
         epc = q_pc.pop_front();
         efl = q_fl.pop_front();
         ec  = q_cnt.pop_front();
         t   = q_tag.pop_front();
         total++;
         if (next_pc !== epc || ifid_flush !== efl || mispredict_cnt !== ec) begin
            bad++;
            $display("FAIL %s: next_pc=%h flush=%b cnt=%h expected next_pc=%h flush=%b cnt=%h",
                     t, next_pc, ifid_flush, mispredict_cnt, epc, efl, ec);
         end
      end
   end

   initial begin
      #(5.0 * 190000);
      bad++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R1: reset state
      repeat (2) @(posedge clk);
      @(negedge clk);
      total++;
      if (ifid_flush !== 1'b0 || mispredict_cnt !== 16'h0 || next_pc !== 32'h104) begin
         bad++;
         $display("FAIL R1 reset: flush=%b cnt=%h next_pc=%h expected 0 0 00000104",
                  ifid_flush, mispredict_cnt, next_pc);
      end
      @(posedge clk); #1 rst_n = 1'b1;

      // R2: straight-line code
      step(0, 16'h0000, 1, "R2 seq");
      step(0, 16'h0000, 0, "R2 seq");
      step(0, 16'h0000, 1, "R2 seq");

      // Loop shape: backward branch -2, taken twice, then exits (R3, R5, R6)
      step(0, 16'h0000, 0, "R2 body");
      step(1, 16'hFFFE, 0, "R3 backward guess");
      step(0, 16'h0000, 1, "R5 loop taken ok");
      step(1, 16'hFFFE, 0, "R3 backward guess");
      step(0, 16'h0000, 1, "R5 loop taken ok");
      step(1, 16'hFFFE, 0, "R3 backward guess");
      step(0, 16'h0000, 0, "R6 loop exit flush");
      step(0, 16'h0000, 0, "R8 count after exit");

      // Skip shape: forward +3, not taken then taken (R4, R5, R7)
      step(1, 16'h0003, 0, "R4 forward guess");
      step(0, 16'h0000, 0, "R5 skip not taken ok");
      step(1, 16'h0003, 0, "R4 forward guess");
      step(0, 16'h0000, 1, "R7 skip taken flush");
      step(0, 16'h0000, 0, "R8 count after skip");

      // Zero offset is forward (R4)
      step(1, 16'h0000, 0, "R4 zero offset");
      step(0, 16'h0000, 0, "R5 zero offset ok");

      // Back-to-back branches, both resolved as guessed (R5)
      step(1, 16'h0005, 0, "R4 first of pair");
      step(1, 16'hFFF0, 0, "R5 pair ok, R3 second");
      step(0, 16'h0000, 1, "R5 pair second ok");

      // R9: branch fetched in flush cycle is squashed, then mismatching outcome ignored
      step(1, 16'h0004, 0, "R4 before flush");
      step(1, 16'hFFF8, 1, "R7 flush with branch in fetch");
      step(0, 16'h0000, 0, "R9 squashed branch ignored");
      step(0, 16'h0000, 1, "R9 idle taken ignored");
      step(0, 16'h0000, 0, "R9 idle");

      // R8: drive misses up to and past saturation
      for (int i = 0; i < 65540; i++) begin
         step(1, 16'h0002, 1, "R8 sat run branch");
         step(0, 16'h0000, 1, "R8 sat run miss");
      end
      step(0, 16'h0000, 0, "R8 saturated hold");
      step(0, 16'h0000, 0, "R8 saturated hold");

      @(posedge clk);
      @(posedge clk);
      total++;
      if (mispredict_cnt !== 16'hFFFF) begin
         bad++;
         $display("FAIL R8 final: cnt=%h expected ffff", mispredict_cnt);
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule